// File: doc/BRIEF.md
# Three-Octave Wavelet Operand Scheduler

This block is the controller that lets one shared filter cell do the work of a three-octave pyramid wavelet decomposition. The filter itself is outside the block. On every clock the scheduler decides where the filter takes its operands from. The choices are the input sample delay line (first octave), a tap of the serial intermediate-result register chain (second or third octave), or nowhere (an idle slot). Each issued computation carries an octave tag. A result strobe with the same tag follows one clock later. The scheduler also tells the register chain when a low-pass result must be shifted in and which tap feeds the filter.

The schedule repeats every eight clocks. First-octave work wants every even cycle. Second-octave work wants cycles 4k+4 and third-octave work wants cycles 8k+10, both counted from the arming cycle. When two octaves want the same cycle, the higher octave wins, and the displaced first-octave computation runs in the following odd cycle. In steady state this fills seven slots out of eight. Nothing is issued until six samples have entered the delay line.

Inside, there is a free-running slot counter, a saturating age counter, three phase detectors built as small state machines, a fourth state machine that holds a displaced request, and a priority decoder that produces the source select.

Top module: `dwt_octave_sched`

## Requirements
- R1: `src_sel` encodes the operand source as 00 = idle, 01 = sample delay line, 10 = register chain for octave 2, 11 = register chain for octave 3. `iss_valid` is high exactly when `src_sel` is not 00. `iss_oct` is 01, 10 or 11 for octaves 1, 2 and 3, and 00 when idle.
- R2: After synchronous reset, `armed` is low and `src_sel` is 00 until six cycles with `smp_in` high have been seen. Cycles with `smp_in` low do not count. `armed` rises in the cycle after the sixth sample and stays high until reset. The cycle in which `armed` first reads high is schedule cycle n = 0.
- R3: During the first period (n = 0..7) with no conflict, octave 1 is issued at n = 0, 2 and 6, and cycles 1, 3 and 7 are idle.
- R4: Octave 2 is issued at n = 4k+4 (4, 8, 12, ...), with `src_sel` = 10.
- R5: Octave 3 is issued at n = 8k+10 (10, 18, ...), with `src_sel` = 11.
- R6: When octave 1 collides with octave 2 or octave 3, the higher octave takes the cycle and octave 1 is issued in the next (odd) cycle. So octave 1 appears at n = 5 and, for n ≥ 8, at n mod 8 = 1, 3 and 5.
- R7: From n = 8 on, the pattern per period (n mod 8 = 0..7) is octave 2, 1, 3, 1, 2, 1, 1, idle. This gives one idle cycle in every eight.
- R8: Every issued computation is followed one clock later by `res_valid` high with `res_oct` equal to the issued tag. `res_valid` is low in the cycle after an idle slot.
- R9: `rb_tap` is 3 during an octave-2 issue, 25 during an octave-3 issue, and 0 otherwise.
- R10: `rb_push` is high exactly when `res_valid` is high and `res_oct` is octave 1 or octave 2.
- R11: Once armed, `smp_in` has no effect on the schedule.
- R12: Synchronous reset during operation clears the schedule. The next arming needs six fresh samples and starts again at n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 1 | A new sample enters the delay line this cycle |
| src_sel | output | 2 | Filter operand source select |
| iss_valid | output | 1 | A computation is issued this cycle |
| iss_oct | output | 2 | Octave tag of the issued computation |
| rb_tap | output | 5 | Register-chain tap feeding the filter |
| res_valid | output | 1 | Filter result from last cycle's issue is ready |
| res_oct | output | 2 | Octave tag of that result |
| rb_push | output | 1 | Shift a low-pass result into the register chain |
| armed | output | 1 | Delay line full, schedule running |

## Verification
Any fault in the phase detectors or counters appears at `src_sel` within one eight-cycle period. An age counter that is off by one shifts the first octave-2 slot away from n = 4 and the first octave-3 slot away from n = 10, so it shows within the first ten armed cycles. A lost displaced request shows in the very next odd cycle as an idle code where 01 belongs. A wrong fill count moves the arming cycle, which shifts the whole issued sequence from its first cycle. The bench compares the full per-cycle select, tag, tap and result sequence over many periods, across gaps in the sample stream and across a reset in mid-run.

// File: rtl/dwt_sched_pkg.sv
package dwt_sched_pkg;

  // Operand source codes driven to the filter's input switch.
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'b00,
    SRC_DELAY = 2'b01,
    SRC_BANK2 = 2'b10,
    SRC_BANK3 = 2'b11
  } src_sel_e;

  // Octave tag carried by an issued computation and by its result.
  typedef enum logic [1:0] {
    OCT_NONE = 2'b00,
    OCT_1    = 2'b01,
    OCT_2    = 2'b10,
    OCT_3    = 2'b11
  } oct_e;

  // Phase detector state: waiting for its first slot, or running.
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } phase_st_e;

  // Displaced request holder state.
  typedef enum logic {
    PD_EMPTY = 1'b0,
    PD_HELD  = 1'b1
  } pend_st_e;

  function automatic src_sel_e src_for_oct(input oct_e o);
    case (o)
      OCT_1:   return SRC_DELAY;
      OCT_2:   return SRC_BANK2;
      OCT_3:   return SRC_BANK3;
      default: return SRC_IDLE;
    endcase
  endfunction

  // A result is stored in the register chain when a later octave still needs it.
  function automatic logic needs_storage(input logic vld, input oct_e o);
    return vld && (o == OCT_1 || o == OCT_2);
  endfunction

endpackage

// File: rtl/dwt_fill_tracker.sv
module dwt_fill_tracker #(
  parameter int unsigned FILL_DEPTH = 6,
  localparam int unsigned FILL_W = $clog2(FILL_DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_in,
  output logic armed
);

  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (smp_in && (fill_q != FILL_W'(FILL_DEPTH))) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  assign armed = (fill_q == FILL_W'(FILL_DEPTH));

endmodule

// File: rtl/dwt_slot_counter.sv
module dwt_slot_counter #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  output logic [CNT_W-1:0] slot,
  output logic [AGE_W-1:0] age
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      age  <= '0;
    end else if (armed) begin
      slot <= slot + 1'b1;
      if (age != AGE_MAX) begin
        age <= age + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwt_phase_fsm.sv
module dwt_phase_fsm
  import dwt_sched_pkg::*;
#(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned AGE_W = 4,
  parameter int unsigned START = 0,
  parameter int unsigned MASK  = 1,
  parameter int unsigned MATCH = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic [CNT_W-1:0] slot,
  input  logic [AGE_W-1:0] age,
  output logic             hit
);

  phase_st_e st_q, st_d;
  logic first_slot;
  logic in_phase;

  assign first_slot = (age == AGE_W'(START));
  assign in_phase   = ((slot & CNT_W'(MASK)) == CNT_W'(MATCH));

  always_comb begin
    st_d = st_q;
    hit  = 1'b0;
    if (armed) begin
      case (st_q)
        PH_WAIT: begin
          if (first_slot) begin
            hit  = 1'b1;
            st_d = PH_RUN;
          end
        end
        PH_RUN: begin
          hit = in_phase;
        end
        default: st_d = PH_WAIT;
      endcase
    end else begin
      st_d = PH_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PH_WAIT;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/dwt_slot_decoder.sv
module dwt_slot_decoder
  import dwt_sched_pkg::*;
#(
  parameter int unsigned TAP_W  = 5,
  parameter int unsigned TAP_O2 = 3,
  parameter int unsigned TAP_O3 = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       hit_vec,
  output src_sel_e         sel,
  output oct_e             oct,
  output logic [TAP_W-1:0] tap,
  output logic             displaced
);

  pend_st_e pend_q, pend_d;
  logic collide;

  // Octave 1 loses its slot whenever a higher octave wants the same cycle.
  assign collide = hit_vec[0] && (hit_vec[1] || hit_vec[2]);

  always_comb begin
    if (hit_vec[2]) begin
      oct = OCT_3;
    end else if (hit_vec[1]) begin
      oct = OCT_2;
    end else if (hit_vec[0] || (pend_q == PD_HELD)) begin
      oct = OCT_1;
    end else begin
      oct = OCT_NONE;
    end
  end

  assign sel       = src_for_oct(oct);
  assign displaced = (pend_q == PD_HELD);

  always_comb begin
    case (oct)
      OCT_2:   tap = TAP_W'(TAP_O2);
      OCT_3:   tap = TAP_W'(TAP_O3);
      default: tap = '0;
    endcase
  end

  assign pend_d = collide ? PD_HELD : PD_EMPTY;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PD_EMPTY;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/dwt_octave_sched.sv
module dwt_octave_sched
  import dwt_sched_pkg::*;
#(
  parameter int unsigned FILL_DEPTH = 6,
  parameter int unsigned RB_DEPTH   = 26,
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned AGE_W      = 4,
  parameter int unsigned O2_START   = 4,
  parameter int unsigned O3_START   = 10,
  parameter int unsigned RB_TAP_O2  = 3,
  parameter int unsigned RB_TAP_O3  = 25,
  localparam int unsigned TAP_W     = $clog2(RB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_in,
  output logic [1:0]       src_sel,
  output logic             iss_valid,
  output logic [1:0]       iss_oct,
  output logic [TAP_W-1:0] rb_tap,
  output logic             res_valid,
  output logic [1:0]       res_oct,
  output logic             rb_push,
  output logic             armed
);

  localparam int unsigned PERIOD = 1 << CNT_W;
  localparam int unsigned P_START [3] = '{0, O2_START, O3_START};
  localparam int unsigned P_MASK  [3] = '{1, (PERIOD / 2) - 1, PERIOD - 1};
  localparam int unsigned P_MATCH [3] = '{0, 0, O3_START % PERIOD};

  logic [CNT_W-1:0] slot;
  logic [AGE_W-1:0] age;
  logic [2:0]       hit_vec;
  src_sel_e         sel_w;
  oct_e             oct_w;
  logic             displaced;
  oct_e             res_oct_q;
  logic             res_valid_q;

  dwt_fill_tracker #(.FILL_DEPTH(FILL_DEPTH)) fill_i (
    .clk   (clk),
    .rst   (rst),
    .smp_in(smp_in),
    .armed (armed)
  );

  dwt_slot_counter #(.CNT_W(CNT_W), .AGE_W(AGE_W)) ctr_i (
    .clk  (clk),
    .rst  (rst),
    .armed(armed),
    .slot (slot),
    .age  (age)
  );

  for (genvar g = 0; g < 3; g++) begin : g_phase
    dwt_phase_fsm #(
      .CNT_W(CNT_W),
      .AGE_W(AGE_W),
      .START(P_START[g]),
      .MASK (P_MASK[g]),
      .MATCH(P_MATCH[g])
    ) ph_i (
      .clk  (clk),
      .rst  (rst),
      .armed(armed),
      .slot (slot),
      .age  (age),
      .hit  (hit_vec[g])
    );
  end

  dwt_slot_decoder #(
    .TAP_W (TAP_W),
    .TAP_O2(RB_TAP_O2),
    .TAP_O3(RB_TAP_O3)
  ) dec_i (
    .clk      (clk),
    .rst      (rst),
    .hit_vec  (hit_vec),
    .sel      (sel_w),
    .oct      (oct_w),
    .tap      (rb_tap),
    .displaced(displaced)
  );

  // One-clock filter latency: the result strobe trails the issue.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_q <= 1'b0;
      res_oct_q   <= OCT_NONE;
    end else begin
      res_valid_q <= (oct_w != OCT_NONE);
      res_oct_q   <= oct_w;
    end
  end

  assign src_sel   = sel_w;
  assign iss_oct   = oct_w;
  assign iss_valid = (sel_w != SRC_IDLE);
  assign res_valid = res_valid_q;
  assign res_oct   = res_oct_q;
  assign rb_push   = needs_storage(res_valid_q, res_oct_q);

endmodule

// File: rtl/dwt_octave_sched_chk.sv
module dwt_octave_sched_chk #(
  parameter int unsigned TAP_W  = 5,
  parameter int unsigned TAP_O3 = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             armed,
  input logic [1:0]       src_sel,
  input logic [1:0]       iss_oct,
  input logic [TAP_W-1:0] rb_tap,
  input logic             res_valid,
  input logic [1:0]       res_oct,
  input logic             rb_push,
  input logic [2:0]       hit_vec,
  input logic             displaced
);

  assert_idle_until_armed_R2: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (src_sel == 2'b00));

  assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_oct != 2'b00) |=> (res_valid && (res_oct == $past(iss_oct))));

  assert_displaced_next_R6: assert property (@(posedge clk) disable iff (rst)
    (src_sel[1] == 1'b1) |=> (src_sel == 2'b01));

  assert_held_request_issued_R6: assert property (@(posedge clk) disable iff (rst)
    displaced |-> (iss_oct == 2'b01));

  assert_phase_hits_sparse_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != 3'b000) |=> (hit_vec == 3'b000));

  assert_tap_oct3_R9: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b11) |-> (rb_tap == TAP_W'(TAP_O3)));

  assert_push_source_R10: assert property (@(posedge clk) disable iff (rst)
    rb_push |-> ($past(src_sel) == 2'b01 || $past(src_sel) == 2'b10));

endmodule

bind dwt_octave_sched dwt_octave_sched_chk #(
  .TAP_W (TAP_W),
  .TAP_O3(RB_TAP_O3)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .armed    (armed),
  .src_sel  (src_sel),
  .iss_oct  (iss_oct),
  .rb_tap   (rb_tap),
  .res_valid(res_valid),
  .res_oct  (res_oct),
  .rb_push  (rb_push),
  .hit_vec  (hit_vec),
  .displaced(displaced)
);

// File: tb/dwt_octave_sched_tb_top.sv
`timescale 1ns/1ps
module dwt_octave_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_in = 1'b0;
  logic [1:0] src_sel;
  logic       iss_valid;
  logic [1:0] iss_oct;
  logic [4:0] rb_tap;
  logic       res_valid;
  logic [1:0] res_oct;
  logic       rb_push;
  logic       armed;

  always #10 clk = ~clk;

  dwt_octave_sched dut_i (
    .clk(clk), .rst(rst), .smp_in(smp_in),
    .src_sel(src_sel), .iss_valid(iss_valid), .iss_oct(iss_oct),
    .rb_tap(rb_tap), .res_valid(res_valid), .res_oct(res_oct),
    .rb_push(rb_push), .armed(armed)
  );

  typedef struct {
    int    sel;
    int    oct;
    int    vld;
    int    rv;
    int    ro;
    int    push;
    int    tap;
    int    arm;
    string tag;
    string phase;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // Bench model state.
  int    mfill = 0;
  int    mn = 0;
  int    cur_oct = 0;
  int    mrv = 0;
  int    mro = 0;
  logic  drv_rst = 1'b1;
  logic  drv_smp = 1'b0;

  // Expected octave for schedule cycle n, written as the requirement tables.
  task automatic slot_of(input int n, output int oct, output string tag);
    int c;
    if (n < 8) begin
      case (n)
        0, 2, 6: begin oct = 1; tag = "R3"; end
        4:       begin oct = 2; tag = "R4"; end
        5:       begin oct = 1; tag = "R6"; end
        default: begin oct = 0; tag = "R3"; end
      endcase
    end else begin
      c = n % 8;
      case (c)
        0, 4:    begin oct = 2; tag = "R4"; end
        2:       begin oct = 3; tag = "R5"; end
        1, 3, 5: begin oct = 1; tag = "R6"; end
        6:       begin oct = 1; tag = "R7"; end
        default: begin oct = 0; tag = "R7"; end
      endcase
    end
  endtask

  // Driver: account for the edge just taken, queue the expected item, apply new inputs.
  task automatic cycle(input logic r, input logic s, input string ph);
    exp_t  e;
    int    o;
    string t;
    @(posedge clk);
    #1;
    if (drv_rst) begin
      mfill = 0; mn = 0; mrv = 0; mro = 0;
    end else begin
      mrv = (cur_oct != 0) ? 1 : 0;
      mro = cur_oct;
      if (mfill == 6) mn++;
      else if (drv_smp) mfill++;
    end
    if (mfill == 6) begin
      slot_of(mn, o, t);
    end else begin
      o = 0; t = "R2";
    end
    cur_oct = o;
    e.sel   = o;
    e.oct   = o;
    e.vld   = (o != 0) ? 1 : 0;
    e.rv    = mrv;
    e.ro    = mro;
    e.push  = (mrv == 1 && (mro == 1 || mro == 2)) ? 1 : 0;
    e.tap   = (o == 2) ? 3 : ((o == 3) ? 25 : 0);
    e.arm   = (mfill == 6) ? 1 : 0;
    e.tag   = t;
    e.phase = ph;
    q.push_back(e);
    drv_rst = r;
    drv_smp = s;
    rst     = r;
    smp_in  = s;
  endtask

  task automatic chk(input int act, input int exp_v, input string req, input string ph);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, ph, act, exp_v);
    end
  endtask

  // Monitor: compares outputs away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(int'(src_sel),   e.sel,  {"R1 sel ", e.tag}, e.phase);
      chk(int'(iss_oct),   e.oct,  {"R1 oct ", e.tag}, e.phase);
      chk(int'(iss_valid), e.vld,  {"R1 valid ", e.tag}, e.phase);
      chk(int'(res_valid), e.rv,   "R8 res_valid", e.phase);
      chk(int'(res_oct),   e.ro,   "R8 res_oct", e.phase);
      chk(int'(rb_push),   e.push, "R10 rb_push", e.phase);
      chk(int'(rb_tap),    e.tap,  "R9 rb_tap", e.phase);
      chk(int'(armed),     e.arm,  "R2 armed", e.phase);
    end
  end

  initial begin
    // Reset, then fill with gaps in the sample stream (R2).
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "reset");
    cycle(1'b0, 1'b1, "fill R2");
    cycle(1'b0, 1'b0, "fill R2");
    cycle(1'b0, 1'b1, "fill R2");
    cycle(1'b0, 1'b1, "fill R2");
    cycle(1'b0, 1'b0, "fill R2");
    cycle(1'b0, 1'b0, "fill R2");
    cycle(1'b0, 1'b1, "fill R2");
    cycle(1'b0, 1'b1, "fill R2");
    cycle(1'b0, 1'b1, "fill R2");
    // Running: samples keep arriving, then toggle and stop (R11).
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, "run");
    for (int i = 0; i < 30; i++) cycle(1'b0, ((i % 3) == 0), "run R11 smp toggled");
    // Reset in mid-run, refill and check the restart (R12).
    cycle(1'b1, 1'b1, "R12 reset");
    cycle(1'b1, 1'b0, "R12 reset");
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, "R12 refill");
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, "R12 restart");
    cycle(1'b0, 1'b0, "tail");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule